// File: doc/BRIEF.md
# UART Interrupt Status Aggregator

This block gathers nine interrupt sources of a serial port into one interrupt line. Four sources are single-cycle pulses from the receive datapath: parity error, framing error, receive overflow and break. Two come from the modem-control inputs, which flag any change of level. The receive-full and transmit-empty sources compare the FIFO fill levels against programmable thresholds. The receive-timeout source comes from a small state machine that measures the gap after each received byte. Every source sets a sticky raw bit. Software masks the raw bits with an enable word, reads the masked status, and removes raw bits by writing ones to a clear word.

Access is through a write port (`wr_en`, `wr_addr`, `wr_data`) and a separate combinational read port (`rd_addr`, `rd_data`). The address map is: 0 raw (read only), 1 status (read only), 2 enable (read/write), 3 clear (write only, reads zero), 4 configuration (read/write). Any other address reads zero. The timeout state machine has three states. TMO_IDLE means no byte has been seen since the timeout was enabled. TMO_WAIT counts timing ticks since the last byte. TMO_FIRED means the timeout for this gap has already been reported. Its transitions are: IDLE to WAIT on a byte, WAIT to WAIT (count restarts) on a byte, WAIT to FIRED on the expiring tick, and FIRED to WAIT on a byte. Clearing the enable forces any state back to IDLE.

Top module: `uart_irq_agg`

## Requirements
- R1: After reset, the raw, status, enable and configuration words read zero and `irq` is 0. Raw bit positions are: 0 rx full, 1 tx empty, 2 parity error, 3 frame error, 4 rx overflow, 5 DSR change, 6 CTS change, 7 break, 8 receive timeout.
- R2: The status word (address 1) equals the raw word ANDed with the enable word (address 2, bits 8:0).
- R3: Raw bits are sticky. A write to address 3 clears each raw bit whose data bit is 1 and leaves every other raw bit unchanged. Address 3 reads zero.
- R4: If a source sets a raw bit in the same cycle that a clear write targets it, the bit stays set.
- R5: Raw bit 0 is set in every cycle where `rx_level` is greater than the receive threshold.
- R6: Raw bit 1 is set in every cycle where `tx_level` is less than the transmit threshold.
- R7: A pulse on `ev_parity_err`, `ev_frame_err`, `ev_rx_ovf` or `ev_break` sets raw bit 2, 3, 4 or 7 at the same clock edge.
- R8: Any change of `dsr_in` sets raw bit 5, and any change of `cts_in` sets raw bit 6. After reset, both inputs are taken to have been high.
- R9: With the timeout enabled, raw bit 8 sets at the (threshold+1)-th `bit_tick` after an `rx_byte` pulse. A new `rx_byte` restarts the count, and `rx_byte` wins over a tick in the same cycle. The timeout fires only once per gap.
- R10: While the timeout enable is 0, raw bit 8 never sets, and the count is abandoned.
- R11: `irq` is the OR of the status bits, registered: it follows the status word one clock later.
- R12: Configuration word (address 4): bits 6:0 receive threshold, bits 14:8 transmit threshold, bits 22:16 timeout threshold, bit 23 timeout enable. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_rx_ovf | input | 1 | Receive overflow pulse |
| ev_break | input | 1 | Break detected pulse |
| dsr_in | input | 1 | Data-set-ready line level |
| cts_in | input | 1 | Clear-to-send line level |
| rx_level | input | CNT_W | Receive FIFO fill count |
| tx_level | input | CNT_W | Transmit FIFO fill count |
| rx_byte | input | 1 | Pulse when a byte enters the receive FIFO |
| bit_tick | input | 1 | Timing strobe for the timeout count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
A raw bit that is lost, set from the wrong source or not cleared shows in the raw read at the next falling edge after the causing clock edge. It shows on `irq` one cycle after that, if the bit is enabled. A timeout state machine that counts wrongly moves the edge where raw bit 8 appears by one or more ticks, or makes it fire twice in one gap. The bench therefore reads raw bit 8 after every single tick around the expiry. A broken set-over-clear priority leaves a zero in the raw word right after a colliding write.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int N_SRC = 9;
    localparam int THR_W = 7;

    localparam int B_RXFULL  = 0;
    localparam int B_TXEMPTY = 1;
    localparam int B_PARITY  = 2;
    localparam int B_FRAME   = 3;
    localparam int B_RXOVF   = 4;
    localparam int B_DSR     = 5;
    localparam int B_CTS     = 6;
    localparam int B_BREAK   = 7;
    localparam int B_TOUT    = 8;

    typedef enum logic [2:0] {
        A_RAW  = 3'd0,
        A_STAT = 3'd1,
        A_ENA  = 3'd2,
        A_CLR  = 3'd3,
        A_CFG  = 3'd4
    } addr_e;

    typedef enum logic [1:0] {
        TMO_IDLE  = 2'd0,
        TMO_WAIT  = 2'd1,
        TMO_FIRED = 2'd2
    } tmo_state_e;

    typedef struct packed {
        logic             tout_en;
        logic [THR_W-1:0] tout_thr;
        logic             pad_b;
        logic [THR_W-1:0] tx_thr;
        logic             pad_a;
        logic [THR_W-1:0] rx_thr;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/uart_irq_edge.sv
module uart_irq_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] chg
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b1;
            else        prev_q[i] <= lvl[i];
        end
        assign chg[i] = lvl[i] ^ prev_q[i];
    end
endmodule

// File: rtl/uart_irq_level.sv
module uart_irq_level
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    input  logic [THR_W-1:0] rx_thr,
    input  logic [THR_W-1:0] tx_thr,
    output logic             rx_over,
    output logic             tx_under
);
    localparam int PAD_W = CNT_W - THR_W;

    logic [CNT_W-1:0] rx_thr_x;
    logic [CNT_W-1:0] tx_thr_x;

    assign rx_thr_x = {{PAD_W{1'b0}}, rx_thr};
    assign tx_thr_x = {{PAD_W{1'b0}}, tx_thr};
    assign rx_over  = rx_level > rx_thr_x;
    assign tx_under = tx_level < tx_thr_x;
endmodule

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [THR_W-1:0] thr,
    input  logic             rx_byte,
    input  logic             bit_tick,
    output logic             fire
);
    tmo_state_e       state_q, state_d;
    logic [THR_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!en) begin
            state_d = TMO_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TMO_IDLE: begin
                    if (rx_byte) begin
                        state_d = TMO_WAIT;
                        cnt_d   = '0;
                    end
                end
                TMO_WAIT: begin
                    if (rx_byte) begin
                        cnt_d = '0;
                    end else if (bit_tick) begin
                        if (cnt_q == thr) state_d = TMO_FIRED;
                        else              cnt_d   = cnt_q + 1'b1;
                    end
                end
                TMO_FIRED: begin
                    if (rx_byte) begin
                        state_d = TMO_WAIT;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = TMO_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        fire = en && (state_q == TMO_WAIT) && !rx_byte && bit_tick && (cnt_q == thr);
    end
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_parity_err,
    input  logic             ev_frame_err,
    input  logic             ev_rx_ovf,
    input  logic             ev_break,
    input  logic             dsr_in,
    input  logic             cts_in,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    input  logic             rx_byte,
    input  logic             bit_tick,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [2:0]       rd_addr,
    output logic [31:0]      rd_data,
    output logic             irq
);
    logic [N_SRC-1:0] raw_q, raw_d, ena_q, set_v, clr_v;
    cfg_t             cfg_q;
    logic             irq_q;
    logic             rx_over, tx_under, tmo_fire;
    logic [1:0]       modem_chg;
    logic             unused_wr;

    assign unused_wr = &{1'b0, wr_data[31:CFG_W]};

    uart_irq_level #(.CNT_W(CNT_W)) u_level (
        .rx_level (rx_level),
        .tx_level (tx_level),
        .rx_thr   (cfg_q.rx_thr),
        .tx_thr   (cfg_q.tx_thr),
        .rx_over  (rx_over),
        .tx_under (tx_under)
    );

    uart_irq_edge #(.N(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({cts_in, dsr_in}),
        .chg   (modem_chg)
    );

    uart_irq_tmo u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_q.tout_en),
        .thr      (cfg_q.tout_thr),
        .rx_byte  (rx_byte),
        .bit_tick (bit_tick),
        .fire     (tmo_fire)
    );

    always_comb begin
        set_v            = '0;
        set_v[B_RXFULL]  = rx_over;
        set_v[B_TXEMPTY] = tx_under;
        set_v[B_PARITY]  = ev_parity_err;
        set_v[B_FRAME]   = ev_frame_err;
        set_v[B_RXOVF]   = ev_rx_ovf;
        set_v[B_DSR]     = modem_chg[0];
        set_v[B_CTS]     = modem_chg[1];
        set_v[B_BREAK]   = ev_break;
        set_v[B_TOUT]    = tmo_fire;
    end

    always_comb begin
        clr_v = '0;
        if (wr_en && (wr_addr == A_CLR)) clr_v = wr_data[N_SRC-1:0];
        raw_d = (raw_q & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
            ena_q <= '0;
            cfg_q <= '0;
            irq_q <= 1'b0;
        end else begin
            raw_q <= raw_d;
            irq_q <= |(raw_q & ena_q);
            if (wr_en && (wr_addr == A_ENA)) ena_q <= wr_data[N_SRC-1:0];
            if (wr_en && (wr_addr == A_CFG)) begin
                cfg_q       <= wr_data[CFG_W-1:0];
                cfg_q.pad_a <= 1'b0;
                cfg_q.pad_b <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_RAW:   rd_data[N_SRC-1:0] = raw_q;
            A_STAT:  rd_data[N_SRC-1:0] = raw_q & ena_q;
            A_ENA:   rd_data[N_SRC-1:0] = ena_q;
            A_CFG:   rd_data[CFG_W-1:0] = cfg_q;
            default: rd_data = '0;
        endcase
    end

    assign irq = irq_q;
endmodule

// File: rtl/uart_irq_agg_chk.sv
module uart_irq_agg_chk
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [N_SRC-1:0] clr_data,
    input logic             ev_parity_err,
    input logic             dsr_in,
    input logic [CNT_W-1:0] tx_level,
    input logic [N_SRC-1:0] raw_q,
    input logic [N_SRC-1:0] ena_q,
    input cfg_t             cfg_q,
    input logic             irq
);
    // R3
    property raw_hold_p;
        @(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(raw_q) & ~(($past(wr_en) && ($past(wr_addr) == A_CLR)) ? $past(clr_data) : '0)) & ~raw_q) == '0);
    endproperty
    raw_hold_chk: assert property (raw_hold_p);

    // R7 R4
    parity_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_parity_err |=> raw_q[B_PARITY]);

    // R6
    tx_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level < {{(CNT_W-THR_W){1'b0}}, cfg_q.tx_thr}) |=> raw_q[B_TXEMPTY]);

    // R8
    dsr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsr_in != $past(dsr_in)) |=> raw_q[B_DSR]);

    // R10
    tout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.tout_en |=> !$rose(raw_q[B_TOUT]));

    // R11
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(raw_q) & $past(ena_q))));
endmodule

bind uart_irq_agg uart_irq_agg_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .clr_data      (wr_data[8:0]),
    .ev_parity_err (ev_parity_err),
    .dsr_in        (dsr_in),
    .tx_level      (tx_level),
    .raw_q         (raw_q),
    .ena_q         (ena_q),
    .cfg_q         (cfg_q),
    .irq           (irq)
);

// File: tb/uart_irq_agg_test.sv
module uart_irq_agg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_parity_err = 0, ev_frame_err = 0, ev_rx_ovf = 0, ev_break = 0;
    logic        dsr_in = 1, cts_in = 1;
    logic [7:0]  rx_level = 0, tx_level = 0;
    logic        rx_byte = 0, bit_tick = 0;
    logic        wr_en = 0;
    logic [2:0]  wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic        irq;
    int          checks = 0, errors = 0;

    always #10 clk = ~clk;

    uart_irq_agg #(.CNT_W(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .ev_parity_err(ev_parity_err), .ev_frame_err(ev_frame_err),
        .ev_rx_ovf(ev_rx_ovf), .ev_break(ev_break),
        .dsr_in(dsr_in), .cts_in(cts_in),
        .rx_level(rx_level), .tx_level(tx_level),
        .rx_byte(rx_byte), .bit_tick(bit_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_data = 0;
    endtask

    task automatic raw_is(input string req, input logic [31:0] exp);
        logic [31:0] d;
        rd(3'd0, d);
        check(req, d, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1;
            @(negedge clk);
            bit_tick = 0;
        end
    endtask

    task automatic byte_in();
        rx_byte = 1;
        @(negedge clk);
        rx_byte = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        raw_is("R1 raw after reset", 0);
        rd(3'd1, d); check("R1 status after reset", d, 0);
        rd(3'd2, d); check("R1 enable after reset", d, 0);
        rd(3'd4, d); check("R1 config after reset", d, 0);
        check("R1 irq after reset", {31'b0, irq}, 0);
    endtask

    task automatic t_pulses();
        logic [31:0] d;
        ev_parity_err = 1; @(negedge clk); ev_parity_err = 0;
        raw_is("R7 parity bit 2", 32'h004);
        ev_frame_err = 1; @(negedge clk); ev_frame_err = 0;
        raw_is("R7 frame bit 3 sticky", 32'h00C);
        ev_rx_ovf = 1; @(negedge clk); ev_rx_ovf = 0;
        ev_break = 1; @(negedge clk); ev_break = 0;
        raw_is("R7 overflow bit 4 and break bit 7", 32'h09C);
        @(negedge clk);
        check("R11 irq low with nothing enabled", {31'b0, irq}, 0);
        wr(3'd3, 32'h014);
        raw_is("R3 partial clear", 32'h088);
        rd(3'd3, d); check("R3 clear word reads zero", d, 0);
        wr(3'd3, 32'h1FF);
        raw_is("R3 full clear", 0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(3'd2, 32'hFFFF_FE04);
        rd(3'd2, d); check("R2 enable readback", d, 32'h004);
        ev_frame_err = 1; @(negedge clk); ev_frame_err = 0;
        rd(3'd1, d); check("R2 status masks frame bit", d, 0);
        ev_parity_err = 1; @(negedge clk); ev_parity_err = 0;
        rd(3'd1, d); check("R2 status shows parity", d, 32'h004);
        check("R11 irq not yet set in raw cycle", {31'b0, irq}, 0);
        @(negedge clk);
        check("R11 irq one cycle later", {31'b0, irq}, 1);
        wr(3'd3, 32'h004);
        check("R11 irq still high in clear cycle", {31'b0, irq}, 1);
        @(negedge clk);
        check("R11 irq drops after clear", {31'b0, irq}, 0);
        wr(3'd3, 32'h1FF);
        wr(3'd2, 0);
    endtask

    task automatic t_setwins();
        ev_break = 1;
        wr(3'd3, 32'h080);
        ev_break = 0;
        raw_is("R4 set wins over clear", 32'h080);
        wr(3'd3, 32'h080);
        raw_is("R4 clear without set", 0);
    endtask

    task automatic t_levels();
        logic [31:0] d;
        tx_level = 8'd10;
        wr(3'd4, {8'h00, 8'h00, 8'h03, 8'h05});
        rx_level = 8'd5; @(negedge clk);
        raw_is("R5 equal level does not set", 0);
        rx_level = 8'd6; @(negedge clk);
        raw_is("R5 level above threshold", 32'h001);
        wr(3'd3, 32'h001);
        raw_is("R5 re-set while above", 32'h001);
        rx_level = 0;
        wr(3'd3, 32'h001);
        tx_level = 8'd3; @(negedge clk);
        raw_is("R6 equal level does not set", 0);
        tx_level = 8'd2; @(negedge clk);
        raw_is("R6 level below threshold", 32'h002);
        tx_level = 8'd10;
        wr(3'd3, 32'h1FF);
        raw_is("R6 clear after level leaves", 0);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d); check("R12 config layout", d, 32'h00FF_7F7F);
        tx_level = 8'd200;
        wr(3'd4, 0);
        tx_level = 0;
        wr(3'd3, 32'h1FF);
    endtask

    task automatic t_modem();
        dsr_in = 0; @(negedge clk);
        raw_is("R8 DSR falling", 32'h020);
        wr(3'd3, 32'h020);
        @(negedge clk);
        raw_is("R8 DSR steady no set", 0);
        dsr_in = 1; @(negedge clk);
        raw_is("R8 DSR rising", 32'h020);
        wr(3'd3, 32'h1FF);
        cts_in = 0; @(negedge clk);
        raw_is("R8 CTS falling", 32'h040);
        wr(3'd3, 32'h1FF);
        cts_in = 1; @(negedge clk);
        raw_is("R8 CTS rising", 32'h040);
        wr(3'd3, 32'h1FF);
    endtask

    task automatic t_timeout();
        wr(3'd4, 32'h0083_0000);
        byte_in();
        ticks(3);
        raw_is("R9 no timeout after thr ticks", 0);
        ticks(1);
        raw_is("R9 timeout at thr+1 ticks", 32'h100);
        wr(3'd3, 32'h100);
        ticks(6);
        raw_is("R9 fires once per gap", 0);
        byte_in();
        ticks(2);
        rx_byte = 1; bit_tick = 1; @(negedge clk); rx_byte = 0; bit_tick = 0;
        ticks(3);
        raw_is("R9 byte restarts count", 0);
        ticks(1);
        raw_is("R9 fires after restart", 32'h100);
        wr(3'd3, 32'h100);
        byte_in();
        ticks(2);
        wr(3'd4, 32'h0003_0000);
        ticks(10);
        raw_is("R10 disabled never fires", 0);
        wr(3'd4, 32'h0083_0000);
        ticks(10);
        raw_is("R10 count abandoned when disabled", 0);
        wr(3'd4, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_pulses();
        t_enable();
        t_setwins();
        t_levels();
        t_modem();
        t_timeout();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule